// File: doc/BRIEF.md
# Software-Triggered Reset Pulse Sequencer

This block turns one register write into a timed internal reset. It watches the register write port of a chip core. When software writes a 3-bit start key to the reset control field, the block drives an internal reset line high for a fixed number of core clock cycles. It then holds that line low for the same number of cycles before it will take another trigger. With the defaults and a 77.76 MHz core clock, the whole sequence lasts 200 cycles, or about 2.57 µs.

While a sequence is running, the block ignores writes to the control field, so a second write can neither restart nor stretch the pulse. There is one exception: a trigger written in the last cycle of the low phase is accepted. In that case the next high phase follows with no idle cycle in between. A busy flag tells the rest of the core that a sequence is in progress. The reset line comes directly from a flip-flop, so it can change only on a clock edge.

Top module: `swrst_seq`

## Requirements
- R1: A sequence starts when, on a clock edge with the block idle, `wrEn` is high, `wrAddr` equals 0x000E and `wrData[2:0]` equals binary 101. The upper data bits are ignored.
- R2: A write to address 0x000E with any other value in bits 2..0 does not start a sequence. A write of 101 to any other address does not start one either.
- R3: `swRst` rises on the clock edge that samples the trigger write. It then stays high for exactly 100 clock cycles.
- R4: After the high phase, `swRst` stays low for 100 further cycles, and `busy` stays high during those cycles.
- R5: `busy` is high for exactly the 200 cycles of a sequence and low whenever the block is idle. `swRst` is never high while `busy` is low.
- R6: During a sequence, a write to the control field in any cycle except the last one is ignored. The sequence is neither restarted nor lengthened.
- R7: A valid trigger in the last cycle of the low phase is accepted. `swRst` rises on the very next edge and a full new sequence follows.
- R8: `rstN` is active low and asynchronous. While it is low, `swRst` and `busy` are low immediately and the cycle counter is cleared, so the next trigger gives a full-length sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that times both phases |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Register write address |
| wrData | input | 16 | Register write data; bits 2..0 hold the key |
| swRst | output | 1 | Registered internal reset pulse |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The lockout and the acceptance of a new trigger can fall in the same cycle: the last cycle of the low phase is where the running sequence finishes and where a new write must be taken. The bench injects trigger writes at a range of offsets into a running sequence, including the last high cycle, the first low cycle, the next-to-last cycle and the final cycle. Each injection is judged by following `swRst` and `busy` cycle by cycle against an arithmetic model. Only the final-cycle injection may start a second, back-to-back sequence. An invalid key written at that same offset must not start one.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // load counter, raise pulse
    logic endHigh;  // clear counter, drop pulse
    logic finish;   // clear counter on return to idle
    logic advance;  // count one cycle
  } seqStrb_t;

endpackage

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int KEY_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h000E,
  parameter logic [KEY_W-1:0] START_KEY = 3'b101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hiDone,
  input  logic              loDone,
  output seqStrb_t          strb,
  output logic              busy
);

  phase_t phase;
  phase_t phaseNext;
  logic   keyHit;
  logic   lastLow;
  logic   accept;

  assign keyHit  = wrEn && (wrAddr == CTRL_ADDR) && (wrData[KEY_W-1:0] == START_KEY);
  assign lastLow = (phase == PH_LOW) && loDone;
  assign accept  = keyHit && ((phase == PH_IDLE) || lastLow);

  always_comb begin
    strb.start   = accept;
    strb.endHigh = (phase == PH_HIGH) && hiDone;
    strb.finish  = lastLow && !accept;
    strb.advance = (phase != PH_IDLE);
  end

  always_comb begin
    phaseNext = phase;
    if (accept) begin
      phaseNext = PH_HIGH;
    end else if (strb.endHigh) begin
      phaseNext = PH_LOW;
    end else if (strb.finish) begin
      phaseNext = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phaseNext;
    end
  end

  assign busy = (phase != PH_IDLE);

  AST_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && hiDone) |=> (phase == PH_LOW)); // R4

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !loDone) |=> !$rose(phase == PH_HIGH)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.start, strb.endHigh, strb.finish})); // R7

  AST_LAST_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (lastLow && keyHit) |=> (phase == PH_HIGH)); // R7

endmodule

// File: rtl/swrst_dp.sv
module swrst_dp
  import swrst_pkg::*;
#(
  parameter int HIGH_CYCLES = 100,
  parameter int LOW_CYCLES = 100
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqStrb_t strb,
  output logic     hiDone,
  output logic     loDone,
  output logic     swRst
);

  localparam int MAX_CYCLES = (HIGH_CYCLES > LOW_CYCLES) ? HIGH_CYCLES : LOW_CYCLES;
  localparam int CNT_W = (MAX_CYCLES > 1) ? $clog2(MAX_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;

  assign hiDone = (cnt == CNT_W'(HIGH_CYCLES - 1));
  assign loDone = (cnt == CNT_W'(LOW_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.start || strb.endHigh || strb.finish) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swRst <= 1'b0;
    end else if (strb.start) begin
      swRst <= 1'b1;
    end else if (strb.endHigh) begin
      swRst <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.start && !strb.endHigh && !strb.finish)
      |=> (cnt == $past(cnt) + CNT_W'(1))); // R3

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cnt <= CNT_W'(MAX_CYCLES - 1))); // R4

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !strb.endHigh) |=> (swRst == $past(swRst))); // R3

endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int KEY_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h000E,
  parameter logic [KEY_W-1:0] START_KEY = 3'b101,
  parameter int HIGH_CYCLES = 100,
  parameter int LOW_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              swRst,
  output logic              busy
);

  seqStrb_t strb;
  logic     hiDone;
  logic     loDone;

  swrst_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .CTRL_ADDR(CTRL_ADDR), .START_KEY(START_KEY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hiDone(hiDone), .loDone(loDone), .strb(strb), .busy(busy)
  );

  swrst_dp #(
    .HIGH_CYCLES(HIGH_CYCLES), .LOW_CYCLES(LOW_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hiDone(hiDone), .loDone(loDone), .swRst(swRst)
  );

  AST_RISE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swRst) |-> $past(wrEn && wrAddr == CTRL_ADDR && wrData[KEY_W-1:0] == START_KEY)); // R1

  AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    swRst |-> busy); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && !$past(wrEn)) |-> !busy); // R2

endmodule

// File: tb/swrst_seq_test.sv
`timescale 1ns/1ps
module swrst_seq_test;

  localparam int HI = 100;
  localparam int LO = 100;
  localparam logic [15:0] CADDR = 16'h000E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        swRst;
  logic        busy;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  swrst_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .swRst(swRst), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // drive a one-cycle write; returns at the negedge after the sampling posedge
  task automatic doWrite(input logic [15:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // follow a sequence from the first cycle after its trigger edge
  task automatic runSeq(input string req, input int inj, input logic [15:0] ia,
                        input logic [15:0] id, input bit expRestart);
    for (int i = 0; i < HI + LO; i++) begin
      chk(req, "swRst in sequence", swRst, (i < HI) ? 1'b1 : 1'b0);
      chk(req, "busy in sequence", busy, 1'b1);
      if (i == inj) begin
        wrEn = 1'b1; wrAddr = ia; wrData = id;
      end
      @(negedge clk);
      wrEn = 1'b0;
    end
    if (expRestart) begin
      // R7: back-to-back sequence, no idle gap
      for (int i = 0; i < HI + LO; i++) begin
        chk("R7", "swRst in second sequence", swRst, (i < HI) ? 1'b1 : 1'b0);
        chk("R7", "busy in second sequence", busy, 1'b1);
        @(negedge clk);
      end
    end
    chk(req, "swRst after sequence", swRst, 1'b0);
    chk("R5", "busy after sequence", busy, 1'b0);
  endtask

  task automatic idleFor(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, "swRst idle", swRst, 1'b0);
      chk(req, "busy idle", busy, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1;
    chk("R8", "swRst in reset", swRst, 1'b0);
    chk("R8", "busy in reset", busy, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    idleFor("R5", 3);

    // R1/R2: sweep every key value at the control address
    for (int k = 0; k < 8; k++) begin
      doWrite(CADDR, 16'(k));
      if (k == 5) runSeq("R1", -1, '0, '0, 1'b0);
      else idleFor("R2", 3);
    end

    // R1: upper data bits do not matter
    doWrite(CADDR, 16'hFFFD);
    runSeq("R1", -1, '0, '0, 1'b0);
    doWrite(CADDR, 16'h5A05);
    runSeq("R3", -1, '0, '0, 1'b0);

    // R2: key 101 at addresses one bit away from the control address
    for (int b = 0; b < 16; b++) begin
      doWrite(CADDR ^ (16'h1 << b), 16'h0005);
      idleFor("R2", 2);
    end
    doWrite(16'h0000, 16'h0005);
    idleFor("R2", 2);

    // R6: writes during a sequence are ignored; R7: last cycle accepted
    begin
      int offs[10] = '{0, 1, 50, 98, 99, 100, 101, 150, 197, 198};
      foreach (offs[j]) begin
        doWrite(CADDR, 16'h0005);
        runSeq("R6", offs[j], CADDR, 16'h0005, 1'b0);
      end
    end
    doWrite(CADDR, 16'h0005);
    runSeq("R7", 199, CADDR, 16'h0005, 1'b1);
    // R7: a wrong key on the last cycle does not retrigger
    doWrite(CADDR, 16'h0005);
    runSeq("R7", 199, CADDR, 16'h0007, 1'b0);
    doWrite(CADDR, 16'h0005);
    runSeq("R7", 199, 16'h000F, 16'h0005, 1'b0);

    // R8: hardware reset in the middle of each phase
    for (int p = 0; p < 2; p++) begin
      doWrite(CADDR, 16'h0005);
      repeat (p == 0 ? 30 : 130) @(negedge clk);
      #1 rstN = 1'b0;
      #0.5;
      chk("R8", "swRst immediately in reset", swRst, 1'b0);
      chk("R8", "busy immediately in reset", busy, 1'b0);
      @(negedge clk);
      rstN = 1'b1;
      idleFor("R8", 2);
      doWrite(CADDR, 16'h0005);
      runSeq("R8", -1, '0, '0, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule